// File: doc/BRIEF.md
# Speculative Access Dependence Tracker

This block watches the accesses that parallel processors make to the elements of one shared array while a loop runs speculatively. For every element it keeps a small state record. One bit says whether the element has only been read. One bit says whether a single processor has touched it. A field holds the ID of the processor that touched it first, with a flag that marks the field as filled. Each access names a read or a write, the element index and the requesting processor. The block looks up the element's record, works out the new record and stores it back, all in the same clock cycle.

An element is safe for parallel execution while it is still read-only, or while only one processor has used it. When an element becomes both written and shared, the block reports a conflict on that access's result. It also raises a sticky failure flag, so that the speculative run can be abandoned at once instead of after the loop ends.

A clear command erases every record and drops the flag, ready for the next speculative loop. Each accepted access produces a registered result one cycle later. The result carries the element's updated record and the conflict indication.

Top module: `access_bit_tracker`

## Requirements
- R1: After reset or a clear, `fail_flag` is 0, `rsp_valid` is 0, and every element is untouched. The first access to an untouched element reports `rsp_solo`=1, and a read as that first access reports `rsp_ronly`=1.
- R2: An access accepted in one cycle (`acc_valid`=1, `clr`=0) produces `rsp_valid`=1 in the next cycle, carrying the element's updated record. With no accepted access, `rsp_valid` is 0 in the next cycle.
- R3: The first access to an untouched element records the requester's ID. `rsp_first_pid` then equals that ID on that access and on every later access to the element until a clear.
- R4: A write (`acc_op`=1) clears the element's read-only bit. A read (`acc_op`=0) leaves that bit unchanged.
- R5: An access from a processor whose ID differs from the recorded first ID clears the element's not-shared bit. An access from the recorded processor leaves that bit unchanged.
- R6: When an access leaves an element with both the read-only bit and the not-shared bit cleared, `rsp_conflict` is 1 and `fail_flag` is 1 in the result cycle. A read by several processors followed by a write is one such case; a write by one processor followed by a read from another is another.
- R7: An element read by any number of processors, or written and read by one processor only, never gives `rsp_conflict`=1 and never sets `fail_flag`.
- R8: Once set, `fail_flag` stays 1 until `clr` is sampled high. It is 0 in the cycle after `clr`.
- R9: `clr` takes priority over an access in the same cycle. That access gives no result and leaves the element untouched.
- R10: An access in the cycle right after an access to the same element sees the record written by that earlier access.
- R11: Element indices run from 0 to `NUM_ELEM`-1. The highest index behaves like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Erase all element records and drop the failure flag |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_op | input | 1 | 0 = read, 1 = write |
| acc_idx | input | $clog2(NUM_ELEM) | Element index |
| acc_pid | input | PID_W | Requesting processor ID |
| rsp_valid | output | 1 | Result of the previous cycle's access is present |
| rsp_ronly | output | 1 | Element read-only bit after the access |
| rsp_solo | output | 1 | Element not-shared bit after the access |
| rsp_first_pid | output | PID_W | First processor recorded for the element |
| rsp_conflict | output | 1 | This access left the element written and shared |
| fail_flag | output | 1 | Sticky failure indication |

## Verification
- **Access results:** every result field and the failure flag are due one clock edge after the edge that samples the access. A queued expectation is therefore compared only once the monitor wakes a quarter period after each rising edge and sees `rsp_valid` high.
- **Clear:** its effect is due on the edge that samples it. The bench checks the flag and the absence of any result at the falling edge that follows.
- **Overlapping accesses:** back-to-back accesses to one element are issued on consecutive cycles. This exercises the path from one cycle's write-back to the next cycle's lookup.
- **Clear during an access:** an access issued together with a clear pushes no expectation. Any result it produced would therefore show up as an unexpected item.

// File: rtl/abt_pkg.sv
package abt_pkg;

  typedef enum logic {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } acc_op_e;

  // Per-element status record (owner ID kept separately: its width is a parameter)
  typedef struct packed {
    logic seen;   // owner field is filled
    logic ronly;  // no write observed yet
    logic solo;   // only the owner has touched the element
  } abits_t;

  function automatic abits_t abits_init();
    abits_t b;
    b.seen  = 1'b0;
    b.ronly = 1'b1;
    b.solo  = 1'b1;
    return b;
  endfunction

  // New record from the old one and the classification of the access
  function automatic abits_t abits_next(abits_t cur, logic same_owner, acc_op_e op);
    abits_t n;
    n       = cur;
    n.seen  = 1'b1;
    if (cur.seen && !same_owner) n.solo = 1'b0;
    if (op == ACC_WRITE) n.ronly = 1'b0;
    return n;
  endfunction

  // Element is neither read-only nor private to one processor
  function automatic logic abits_conflict(abits_t b);
    return !b.ronly && !b.solo;
  endfunction

endpackage

// File: rtl/abt_table.sv
module abt_table #(
  parameter int NUM_ELEM = 16,
  parameter int PID_W    = 3,
  localparam int IDX_W   = $clog2(NUM_ELEM)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic [IDX_W-1:0]     rd_idx,
  output abt_pkg::abits_t      rd_bits,
  output logic [PID_W-1:0]     rd_owner,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  abt_pkg::abits_t      wr_bits,
  input  logic [PID_W-1:0]     wr_owner
);
  import abt_pkg::*;

  abits_t           bits_q  [NUM_ELEM];
  logic [PID_W-1:0] owner_q [NUM_ELEM];

  for (genvar gi = 0; gi < NUM_ELEM; gi++) begin : g_elem
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bits_q[gi]  <= abits_init();
        owner_q[gi] <= '0;
      end else if (clr) begin
        bits_q[gi]  <= abits_init();
        owner_q[gi] <= '0;
      end else if (hit) begin
        bits_q[gi]  <= wr_bits;
        owner_q[gi] <= wr_owner;
      end
    end
  end

  assign rd_bits  = bits_q[rd_idx];
  assign rd_owner = owner_q[rd_idx];

endmodule

// File: rtl/abt_update.sv
module abt_update #(
  parameter int PID_W = 3
) (
  input  abt_pkg::abits_t   cur_bits,
  input  logic [PID_W-1:0]  cur_owner,
  input  logic              op,
  input  logic [PID_W-1:0]  pid,
  output abt_pkg::abits_t   nxt_bits,
  output logic [PID_W-1:0]  nxt_owner,
  output logic              fresh,
  output logic              owner_match,
  output logic              conflict
);
  import abt_pkg::*;

  always_comb begin
    fresh       = !cur_bits.seen;
    owner_match = (cur_owner == pid);
    nxt_bits    = abits_next(cur_bits, owner_match, acc_op_e'(op));
    nxt_owner   = fresh ? pid : cur_owner;
    conflict    = abits_conflict(nxt_bits);
  end

endmodule

// File: rtl/abt_result.sv
module abt_result #(
  parameter int PID_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  abt_pkg::abits_t   nxt_bits,
  input  logic [PID_W-1:0]  nxt_owner,
  input  logic              conflict,
  output logic              rsp_valid,
  output logic              rsp_ronly,
  output logic              rsp_solo,
  output logic [PID_W-1:0]  rsp_first_pid,
  output logic              rsp_conflict,
  output logic              fail_flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_ronly     <= 1'b1;
      rsp_solo      <= 1'b1;
      rsp_first_pid <= '0;
      rsp_conflict  <= 1'b0;
      fail_flag     <= 1'b0;
    end else if (clr) begin
      rsp_valid     <= 1'b0;
      rsp_conflict  <= 1'b0;
      fail_flag     <= 1'b0;
    end else begin
      rsp_valid <= take;
      if (take) begin
        rsp_ronly     <= nxt_bits.ronly;
        rsp_solo      <= nxt_bits.solo;
        rsp_first_pid <= nxt_owner;
        rsp_conflict  <= conflict;
        fail_flag     <= fail_flag | conflict;
      end
    end
  end

endmodule

// File: rtl/access_bit_tracker.sv
module access_bit_tracker #(
  parameter int NUM_ELEM = 16,
  parameter int PID_W    = 3,
  localparam int IDX_W   = $clog2(NUM_ELEM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              acc_valid,
  input  logic              acc_op,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [PID_W-1:0]  acc_pid,
  output logic              rsp_valid,
  output logic              rsp_ronly,
  output logic              rsp_solo,
  output logic [PID_W-1:0]  rsp_first_pid,
  output logic              rsp_conflict,
  output logic              fail_flag
);
  import abt_pkg::*;

  // Named internal events, observed by the bound checker
  logic             take;
  logic             fresh;
  logic             owner_match;
  logic             upd_conflict;
  abits_t           cur_bits, nxt_bits;
  logic [PID_W-1:0] cur_owner, nxt_owner;

  assign take = acc_valid && !clr;

  abt_table #(.NUM_ELEM(NUM_ELEM), .PID_W(PID_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .rd_idx   (acc_idx),
    .rd_bits  (cur_bits),
    .rd_owner (cur_owner),
    .wr_en    (take),
    .wr_idx   (acc_idx),
    .wr_bits  (nxt_bits),
    .wr_owner (nxt_owner)
  );

  abt_update #(.PID_W(PID_W)) u_update (
    .cur_bits    (cur_bits),
    .cur_owner   (cur_owner),
    .op          (acc_op),
    .pid         (acc_pid),
    .nxt_bits    (nxt_bits),
    .nxt_owner   (nxt_owner),
    .fresh       (fresh),
    .owner_match (owner_match),
    .conflict    (upd_conflict)
  );

  abt_result #(.PID_W(PID_W)) u_result (
    .clk           (clk),
    .rst_n         (rst_n),
    .clr           (clr),
    .take          (take),
    .nxt_bits      (nxt_bits),
    .nxt_owner     (nxt_owner),
    .conflict      (upd_conflict),
    .rsp_valid     (rsp_valid),
    .rsp_ronly     (rsp_ronly),
    .rsp_solo      (rsp_solo),
    .rsp_first_pid (rsp_first_pid),
    .rsp_conflict  (rsp_conflict),
    .fail_flag     (fail_flag)
  );

endmodule

// File: rtl/abt_checker.sv
module abt_checker #(
  parameter int PID_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             acc_valid,
  input logic             acc_op,
  input logic [PID_W-1:0] acc_pid,
  input logic             take,
  input logic             fresh,
  input logic             owner_match,
  input logic             rsp_valid,
  input logic             rsp_ronly,
  input logic             rsp_solo,
  input logic [PID_W-1:0] rsp_first_pid,
  input logic             rsp_conflict,
  input logic             fail_flag
);

  p_rsp_due_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !clr) |=> rsp_valid);

  p_no_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid || clr) |=> !rsp_valid);

  p_first_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && fresh) |=> (rsp_first_pid == $past(acc_pid)));

  p_write_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && acc_op) |=> !rsp_ronly);

  p_foreign_shares_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !fresh && !owner_match) |=> !rsp_solo);

  p_conflict_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ronly && !rsp_solo) |-> (rsp_conflict && fail_flag));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_flag && !clr) |=> fail_flag);

  p_clear_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !fail_flag);

endmodule

bind access_bit_tracker abt_checker #(.PID_W(PID_W)) u_abt_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .clr           (clr),
  .acc_valid     (acc_valid),
  .acc_op        (acc_op),
  .acc_pid       (acc_pid),
  .take          (take),
  .fresh         (fresh),
  .owner_match   (owner_match),
  .rsp_valid     (rsp_valid),
  .rsp_ronly     (rsp_ronly),
  .rsp_solo      (rsp_solo),
  .rsp_first_pid (rsp_first_pid),
  .rsp_conflict  (rsp_conflict),
  .fail_flag     (fail_flag)
);

// File: tb/access_bit_tracker_bench.sv
module access_bit_tracker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 16;
  localparam int PW = 3;
  localparam int IW = $clog2(NE);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr = 1'b0;
  logic          acc_valid = 1'b0;
  logic          acc_op = 1'b0;
  logic [IW-1:0] acc_idx = '0;
  logic [PW-1:0] acc_pid = '0;
  logic          rsp_valid, rsp_ronly, rsp_solo, rsp_conflict, fail_flag;
  logic [PW-1:0] rsp_first_pid;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  access_bit_tracker #(.NUM_ELEM(NE), .PID_W(PW)) u_access_bit_tracker (
    .clk(clk), .rst_n(rst_n), .clr(clr), .acc_valid(acc_valid), .acc_op(acc_op),
    .acc_idx(acc_idx), .acc_pid(acc_pid), .rsp_valid(rsp_valid), .rsp_ronly(rsp_ronly),
    .rsp_solo(rsp_solo), .rsp_first_pid(rsp_first_pid), .rsp_conflict(rsp_conflict),
    .fail_flag(fail_flag)
  );

  typedef struct {
    logic          ro;
    logic          solo;
    logic [PW-1:0] pid;
    logic          conf;
    logic          flag;
    string         tag;
  } exp_t;

  exp_t exp_q[$];

  // Reference state, kept independently of the design
  bit          m_touched [NE];
  bit          m_written [NE];
  bit          m_many    [NE];
  bit [PW-1:0] m_first   [NE];
  bit          m_flag;

  task automatic model_reset();
    for (int i = 0; i < NE; i++) begin
      m_touched[i] = 0; m_written[i] = 0; m_many[i] = 0; m_first[i] = '0;
    end
    m_flag = 0;
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic acc(bit wr, int idx, int pid, string tag);
    exp_t e;
    @(negedge clk);
    clr = 1'b0; acc_valid = 1'b1; acc_op = wr; acc_idx = IW'(idx); acc_pid = PW'(pid);
    if (!m_touched[idx]) begin
      m_touched[idx] = 1; m_first[idx] = PW'(pid);
    end else if (m_first[idx] != PW'(pid)) begin
      m_many[idx] = 1;
    end
    if (wr) m_written[idx] = 1;
    e.ro   = !m_written[idx];
    e.solo = !m_many[idx];
    e.pid  = m_first[idx];
    e.conf = m_written[idx] && m_many[idx];
    m_flag = m_flag | e.conf;
    e.flag = m_flag;
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      acc_valid = 1'b0; clr = 1'b0;
    end
  endtask

  // Clear, optionally with a same-cycle access that must be dropped
  task automatic clear(bit with_acc, int idx, int pid);
    @(negedge clk);
    clr = 1'b1; acc_valid = with_acc; acc_op = 1'b1; acc_idx = IW'(idx); acc_pid = PW'(pid);
    model_reset();
    @(negedge clk);
    clr = 1'b0; acc_valid = 1'b0;
    check(fail_flag == 1'b0, "R8", "fail_flag after clr", int'(fail_flag), 0);
    check(rsp_valid == 1'b0, "R9", "rsp_valid after clr", int'(rsp_valid), 0);
  endtask

  // Monitor / scoreboard
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2/R9", "unexpected rsp_valid", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rsp_ronly == e.ro, e.tag, "rsp_ronly", int'(rsp_ronly), int'(e.ro));
        check(rsp_solo == e.solo, e.tag, "rsp_solo", int'(rsp_solo), int'(e.solo));
        check(rsp_first_pid == e.pid, e.tag, "rsp_first_pid", int'(rsp_first_pid), int'(e.pid));
        check(rsp_conflict == e.conf, e.tag, "rsp_conflict", int'(rsp_conflict), int'(e.conf));
        check(fail_flag == e.flag, e.tag, "fail_flag", int'(fail_flag), int'(e.flag));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R2 watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(fail_flag == 1'b0, "R1", "fail_flag after reset", int'(fail_flag), 0);
    check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);

    // Element 1: written and read by one processor only
    acc(1, 1, 1, "R4 single writer");
    acc(0, 1, 1, "R7 owner rereads");
    acc(1, 1, 1, "R7 owner rewrites");
    idle(1);

    // Element 2: read-only shared by many
    acc(0, 2, 0, "R1 first read");
    acc(0, 2, 1, "R5 foreign read");
    acc(0, 2, 3, "R7 shared read-only");
    acc(0, 2, 7, "R3 owner kept");
    idle(1);

    // Element 0: several readers then a write
    acc(0, 0, 2, "R3 first owner");
    acc(0, 0, 2, "R5 same owner");
    acc(0, 0, 5, "R5 other reader");
    idle(2);
    acc(1, 0, 5, "R6 read-shared then write");
    idle(2);
    acc(0, 2, 4, "R8 flag stays");
    idle(2);

    clear(1'b0, 0, 0);
    acc(0, 0, 4, "R1 fresh after clear");
    idle(1);

    // Clear with same-cycle access to element 3
    clear(1'b1, 3, 6);
    acc(0, 3, 1, "R9 dropped access left no trace");
    idle(1);

    // Back-to-back on element 5, writer then foreign reader on element 6
    acc(0, 5, 3, "R10 first");
    acc(1, 5, 6, "R10 follow-up sees record");
    acc(1, 6, 2, "R4 write");
    acc(0, 6, 3, "R6 write then foreign read");
    idle(1);

    clear(1'b0, 0, 0);
    // Highest index
    acc(0, NE-1, 0, "R11 top index first");
    acc(0, NE-1, 1, "R11 top index shared");
    acc(1, NE-1, 1, "R11 top index write");
    acc(0, NE-2, 7, "R11 neighbour untouched");
    idle(4);

    check(exp_q.size() == 0, "R2", "results outstanding", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule